// File: doc/BRIEF.md
# Checkpointed Register Rename Map

This block sits between decode and the issue queue of a four-wide out-of-order core that keeps its results in a physical register file. Each cycle it takes up to four instructions, and each instruction names two source registers and one destination register. For every source it returns the physical register that holds the value. Every destination gets a fresh physical register, which removes write-after-read and write-after-write hazards. It also returns the physical register that the destination was mapped to before, and a tag that names the instruction while it is in flight.

A source that reads a register written by an earlier slot of the same group takes that slot's new physical register instead of the table entry. After every instruction the block saves a full copy of the map. A mispredict or an exception on tag T therefore restores the map in one cycle: instruction T is kept, and every younger instruction is dropped and its physical register freed. Retiring the oldest instruction frees its previous physical register. There are 32 architectural registers and 80 physical registers. Architectural register 31 reads as zero, uses physical register 31 for good, and is never renamed.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i (0 to 31) maps to physical register i, physical registers 32 to 79 are free, no instruction is in flight, and the first tag issued is 0.
- R2: A valid slot's physical sources equal the current map entry when no earlier valid slot of the same group writes that register. A source of 31 always gives physical 31.
- R3: When one or more earlier valid slots of the group write a source's register, the source takes the new physical register of the nearest such slot.
- R4: Each valid slot whose destination is not 31 gets the lowest-numbered free physical register that earlier slots of the group have not taken, so lower slots get lower numbers. A destination of 31 reports physical 31 and takes no register.
- R5: The previous-mapping output of a slot is the destination's mapping just before that slot, including any update by earlier slots of the group.
- R6: Tags are 6 bits. Valid slots take consecutive tags modulo 64 in slot order, starting one past the last tag issued. Invalid slots take none.
- R7: ren_ok is 1 only when at least one slot is valid, flush_en is low, the free list holds at least as many registers as the group has destinations, and in-flight entries plus valid slots do not exceed 64. Otherwise the whole group is refused and the map, the free list and the tags are left unchanged.
- R8: commit_en retires the oldest in-flight instruction. If that instruction had a destination, its previous physical register becomes free from the next cycle.
- R9: flush_en with tag T restores the map to its state just after instruction T renamed, frees the new registers of all younger in-flight instructions, and makes the next tag T+1. A commit in the same cycle must name an instruction older than T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 4 | Slot valid, bit k for slot k |
| ren_src_a | input | 20 | First source register, slot k at bits 5k+4:5k |
| ren_src_b | input | 20 | Second source register, same packing |
| ren_dst | input | 20 | Destination register, same packing |
| ren_ok | output | 1 | Group accepted this cycle |
| ren_psrc_a | output | 28 | Physical first source, slot k at bits 7k+6:7k |
| ren_psrc_b | output | 28 | Physical second source, same packing |
| ren_pdst | output | 28 | New physical destination, same packing |
| ren_pold | output | 28 | Previous physical destination, same packing |
| ren_tag | output | 24 | Tag of each slot, slot k at bits 6k+5:6k |
| commit_en | input | 1 | Retire the oldest in-flight instruction |
| flush_en | input | 1 | Roll back to flush_tag |
| flush_tag | input | 6 | Tag of the youngest instruction to keep |

## Verification
The rename outputs and ren_ok are combinational from the inputs and the current state. The bench drives each group just after a falling edge and compares the outputs 1 ns later, in the same cycle. Commits, flushes and allocations take effect at the next rising edge. Their results are therefore checked one cycle later, through the sources, previous mappings and new registers that the following groups get. The bench model applies each cycle's state change before the next cycle's comparison, so each expected value matches the cycle in which the design produces it.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int W     = 4,
  parameter int AREGS = 32,
  parameter int PREGS = 80,
  parameter int DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [W-1:0]                  ren_valid,
  input  logic [W*$clog2(AREGS)-1:0]    ren_src_a,
  input  logic [W*$clog2(AREGS)-1:0]    ren_src_b,
  input  logic [W*$clog2(AREGS)-1:0]    ren_dst,
  output logic                          ren_ok,
  output logic [W*$clog2(PREGS)-1:0]    ren_psrc_a,
  output logic [W*$clog2(PREGS)-1:0]    ren_psrc_b,
  output logic [W*$clog2(PREGS)-1:0]    ren_pdst,
  output logic [W*$clog2(PREGS)-1:0]    ren_pold,
  output logic [W*$clog2(DEPTH)-1:0]    ren_tag,
  input  logic                          commit_en,
  input  logic                          flush_en,
  input  logic [$clog2(DEPTH)-1:0]      flush_tag
);
  localparam int AW = $clog2(AREGS);
  localparam int PW = $clog2(PREGS);
  localparam int TW = $clog2(DEPTH);
  localparam logic [AW-1:0] AZERO = AW'(AREGS - 1);
  localparam logic [PW-1:0] PZERO = PW'(AREGS - 1);

  logic [PW-1:0] map_q  [AREGS];
  logic [PW-1:0] snap_q [DEPTH][AREGS];
  logic [PW-1:0] newp_q [DEPTH];
  logic [PW-1:0] oldp_q [DEPTH];
  logic [DEPTH-1:0] hasd_q;
  logic [PREGS-1:0] free_q;
  logic [TW-1:0] head_q, tail_q;
  logic [TW:0]   cnt_q;

  logic [PW-1:0] gmap [W+1][AREGS];
  logic [PW-1:0] ps_a [W], ps_b [W], pd [W], po [W];
  logic [TW-1:0] tg [W];
  logic [W-1:0]  need;
  logic [PREGS-1:0] avail, used, rel;
  logic [TW-1:0] t, ftoff, off;
  logic          found, commit_do;
  int            nvalid, nneed, nfree;

  always_comb begin
    gmap[0] = map_q;
    avail   = free_q;
    used    = '0;
    t       = tail_q;
    found   = 1'b0;
    for (int k = 0; k < W; k++) begin
      need[k] = ren_valid[k] && (ren_dst[k*AW +: AW] != AZERO);
      ps_a[k] = (ren_src_a[k*AW +: AW] == AZERO) ? PZERO : gmap[k][ren_src_a[k*AW +: AW]];
      ps_b[k] = (ren_src_b[k*AW +: AW] == AZERO) ? PZERO : gmap[k][ren_src_b[k*AW +: AW]];
      po[k]   = gmap[k][ren_dst[k*AW +: AW]];
      pd[k]   = PZERO;
      found   = 1'b0;
      if (need[k])
        for (int p = 0; p < PREGS; p++)
          if (avail[p] && !found) begin
            pd[k] = PW'(p);
            found = 1'b1;
          end
      if (found) begin
        avail[pd[k]] = 1'b0;
        used[pd[k]]  = 1'b1;
      end
      gmap[k+1] = gmap[k];
      if (need[k]) gmap[k+1][ren_dst[k*AW +: AW]] = pd[k];
      tg[k] = t;
      if (ren_valid[k]) t = t + 1'b1;
    end
  end

  assign nvalid    = $countones(ren_valid);
  assign nneed     = $countones(need);
  assign nfree     = $countones(free_q);
  assign ren_ok    = (|ren_valid) && !flush_en && (nfree >= nneed) && (DEPTH - int'(cnt_q) >= nvalid);
  assign commit_do = commit_en && (cnt_q != '0);
  assign ftoff     = flush_tag - head_q;

  always_comb begin
    rel = '0;
    off = '0;
    if (commit_do && hasd_q[head_q]) rel[oldp_q[head_q]] = 1'b1;
    if (flush_en)
      for (int e = 0; e < DEPTH; e++) begin
        off = TW'(e) - head_q;
        if ({1'b0, off} < cnt_q && off > ftoff && hasd_q[e]) rel[newp_q[e]] = 1'b1;
      end
  end

  for (genvar k = 0; k < W; k++) begin : g_out
    assign ren_psrc_a[k*PW +: PW] = ps_a[k];
    assign ren_psrc_b[k*PW +: PW] = ps_b[k];
    assign ren_pdst[k*PW +: PW]   = pd[k];
    assign ren_pold[k*PW +: PW]   = po[k];
    assign ren_tag[k*TW +: TW]    = tg[k];

    assert_alloc_was_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ren_ok && need[k] |-> free_q[pd[k]]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < AREGS; a++) map_q[a] <= PW'(a);
      for (int p = 0; p < PREGS; p++) free_q[p] <= (p >= AREGS);
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      free_q <= (free_q & ~(ren_ok ? used : '0)) | rel;
      if (commit_do) head_q <= head_q + 1'b1;
      if (flush_en) begin
        map_q  <= snap_q[flush_tag];
        tail_q <= flush_tag + 1'b1;
        cnt_q  <= {1'b0, ftoff} + 1'b1 - (TW+1)'(commit_do);
      end else if (ren_ok) begin
        map_q  <= gmap[W];
        tail_q <= t;
        cnt_q  <= cnt_q + (TW+1)'(nvalid) - (TW+1)'(commit_do);
      end else begin
        cnt_q  <= cnt_q - (TW+1)'(commit_do);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ren_ok)
      for (int k = 0; k < W; k++)
        if (ren_valid[k]) begin
          snap_q[tg[k]] <= gmap[k+1];
          newp_q[tg[k]] <= pd[k];
          oldp_q[tg[k]] <= po[k];
          hasd_q[tg[k]] <= need[k];
        end
  end

  assert_zero_never_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !free_q[PZERO]);
  assert_inflight_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);
  assert_alloc_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ren_ok |-> $countones(used) == nneed);
  assert_no_double_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel & free_q) == '0);
  assert_flush_keeps_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en && !commit_do |=> cnt_q != '0);
endmodule

// File: tb/rename_map_tb.sv
module rename_map_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [3:0]  ren_valid;
  logic [19:0] ren_src_a, ren_src_b, ren_dst;
  logic        ren_ok;
  logic [27:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;
  logic [23:0] ren_tag;
  logic        commit_en, flush_en;
  logic [5:0]  flush_tag;

  rename_map dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  int mmap[32];
  bit mfree[80];
  int msnap[64][32];
  int mnew[64], mold[64];
  bit mhas[64];
  int head, tail, cnt;

  task automatic chk(string r, string note, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, note, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] v, input int s1[4], input int s2[4], input int d[4],
                     input bit cm, input bit fl, input int ft, input string note);
    int gm[32]; bit av[80]; int pd[4], po[4], tg[4]; bit need[4]; int sk[4][32];
    int t, nv, nn, fc, e1, e2, cdo, h0, off; bit eok, f1, f2;
    ren_valid = v; commit_en = cm; flush_en = fl; flush_tag = 6'(ft);
    for (int k = 0; k < 4; k++) begin
      ren_src_a[k*5 +: 5] = 5'(s1[k]); ren_src_b[k*5 +: 5] = 5'(s2[k]); ren_dst[k*5 +: 5] = 5'(d[k]);
    end
    #1;
    gm = mmap; av = mfree; t = tail; nv = 0; nn = 0; fc = 0;
    foreach (mfree[p]) fc += mfree[p];
    for (int k = 0; k < 4; k++) begin
      need[k] = v[k] && d[k] != 31;
      nv += v[k]; nn += need[k];
    end
    eok = (v != 0) && !fl && fc >= nn && (64 - cnt) >= nv;
    chk("R7", note, ren_ok, eok);
    for (int k = 0; k < 4; k++) begin
      f1 = 0; f2 = 0;
      for (int j = 0; j < k; j++) begin
        if (need[j] && d[j] == s1[k]) f1 = 1;
        if (need[j] && d[j] == s2[k]) f2 = 1;
      end
      e1 = (s1[k] == 31) ? 31 : gm[s1[k]];
      e2 = (s2[k] == 31) ? 31 : gm[s2[k]];
      po[k] = gm[d[k]]; pd[k] = 31;
      if (need[k])
        for (int p = 0; p < 80; p++) if (av[p]) begin pd[k] = p; av[p] = 0; break; end
      if (need[k]) gm[d[k]] = pd[k];
      sk[k] = gm; tg[k] = t;
      if (v[k]) begin
        chk(f1 ? "R3" : "R2", note, int'(ren_psrc_a[k*7 +: 7]), e1);
        chk(f2 ? "R3" : "R2", note, int'(ren_psrc_b[k*7 +: 7]), e2);
        if (eok) begin
          chk("R4", note, int'(ren_pdst[k*7 +: 7]), pd[k]);
          chk("R5", note, int'(ren_pold[k*7 +: 7]), po[k]);
          chk("R6", note, int'(ren_tag[k*6 +: 6]), tg[k]);
        end
        t = (t + 1) % 64;
      end
    end
    cdo = (cm && cnt > 0) ? 1 : 0; h0 = head;
    if (cdo != 0) begin
      if (mhas[head]) mfree[mold[head]] = 1;
      head = (head + 1) % 64;
    end
    if (fl) begin
      off = (ft - h0 + 64) % 64;
      for (int o = off + 1; o < cnt; o++)
        if (mhas[(h0 + o) % 64]) mfree[mnew[(h0 + o) % 64]] = 1;
      mmap = msnap[ft]; tail = (ft + 1) % 64; cnt = off + 1 - cdo;
    end else if (eok) begin
      for (int k = 0; k < 4; k++) if (v[k]) begin
        if (need[k]) mfree[pd[k]] = 0;
        msnap[tg[k]] = sk[k]; mnew[tg[k]] = pd[k]; mold[tg[k]] = po[k]; mhas[tg[k]] = need[k];
      end
      mmap = gm; tail = t; cnt = cnt + nv - cdo;
    end else cnt -= cdo;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rnd(int cprob, int d31prob, int fdiv, int n);
    int s1[4], s2[4], d[4]; bit fl, cm; int ft;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 4; k++) begin
        s1[k] = $urandom % 32; s2[k] = $urandom % 32;
        d[k] = ($urandom % 100 < d31prob) ? 31 : ($urandom % 8);
      end
      fl = cnt > 0 && ($urandom % fdiv == 0);
      ft = fl ? (head + $urandom % cnt) % 64 : 0;
      cm = !fl && cnt > 0 && ($urandom % 100 < cprob);
      run(4'($urandom), s1, s2, d, cm, fl, ft, "sweep");
    end
  endtask

  initial begin
    int z[4] = '{31, 31, 31, 31};
    rst_n = 0; ren_valid = 0; ren_src_a = 0; ren_src_b = 0; ren_dst = 0;
    commit_en = 0; flush_en = 0; flush_tag = 0;
    foreach (mmap[a]) mmap[a] = a;
    foreach (mfree[p]) mfree[p] = (p >= 32);
    head = 0; tail = 0; cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset mapping and first tags
    run(4'hf, '{0, 1, 2, 3}, '{4, 5, 6, 31}, z, 0, 0, 0, "R1 reset map");
    run(4'hf, '{2, 1, 1, 1}, '{3, 0, 1, 5}, '{1, 1, 5, 31}, 0, 0, 0, "R3 group chain");
    repeat (5) run(4'h0, z, z, z, 1, 0, 0, "R8 commit");
    run(4'h1, '{1, 0, 0, 0}, z, '{9, 31, 31, 31}, 0, 0, 0, "R8 reuse freed");
    run(4'hf, '{2, 2, 2, 2}, z, '{2, 2, 2, 2}, 0, 0, 0, "R9 setup");
    run(4'h0, z, z, z, 0, 1, (tail + 61) % 64, "R9 flush");
    run(4'h3, '{2, 9, 0, 0}, '{1, 31, 0, 0}, '{3, 4, 31, 31}, 0, 0, 0, "R9 restored");
    rnd(5, 5, 60, 3000);
    rnd(5, 95, 60, 3000);
    rnd(60, 30, 12, 6000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule